// File: doc/BRIEF.md
# Eight-Operation Adder-Based ALU

This block is a purely combinational arithmetic and logic unit whose width is a parameter (four bits by default). A three-bit opcode picks one of eight functions: add, subtract, increment, pass-through of A, bitwise AND, OR, XOR, and the complement of A. The outputs are the result word and a carry-out.

Every function is produced by one shared ripple-carry adder. In front of it sits one operand-shaping cell per bit, which turns the bits of A and B into the two adder inputs. A small carry-in generator supplies the adder's carry-in. For the logic functions, the bitwise result travels on the first adder input while the second input and the carry-in stay at zero, so the adder passes it through unchanged. Subtraction uses two's complement: the second adder input is the inverse of B and the carry-in is 1.

The opcode is read as bits X (bit 2), Y (bit 1) and Z (bit 0). The block has no clock, no reset and no internal state. Its outputs follow its inputs after the propagation delay of the shaping cells and the carry chain.

Top module: `alu8_top`

## Requirements
- R1: With opcode 000 the result is (A + B) mod 2^WIDTH and the carry-out is the carry from the most significant bit of that sum.
- R2: With opcode 001 the result is (A − B) mod 2^WIDTH and the carry-out is 1 exactly when A ≥ B (unsigned).
- R3: With opcode 010 the result is (A + 1) mod 2^WIDTH and the carry-out is 1 exactly when A is all ones.
- R4: With opcode 011 the result equals A and the carry-out is 0.
- R5: With opcode 100 the result is the bitwise AND of A and B and the carry-out is 0.
- R6: With opcode 101 the result is the bitwise OR of A and B and the carry-out is 0.
- R7: With opcode 110 the result is the bitwise XOR of A and B and the carry-out is 0.
- R8: With opcode 111 the result is the bitwise complement of A and the carry-out is 0.
- R9: With opcodes 010, 011 and 111, operand B has no effect on either the result or the carry-out.
- R10: The adder carry-in is 1 only for opcodes 001 and 010, and the second adder input is zero for every opcode whose X or Y bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Opcode {X,Y,Z} selecting one of the eight functions |
| a_in | input | WIDTH | Operand A |
| b_in | input | WIDTH | Operand B |
| result_o | output | WIDTH | Function result |
| carry_o | output | 1 | Carry out of the most significant adder bit |

## Verification
The hardest case is when the injected carry-in and a full-length ripple through the chain both happen for the same input word. This occurs when incrementing an all-ones A, or when subtracting zero, where the inverted B is all ones. Both the carry-in path and the carry-out path are then active together. These inputs are placed in the directed vector table, and every opcode is also swept over all operand pairs at four bits. Each response is compared with an arithmetic model built from the requirements, and the carry-out is checked on its own against the expected no-borrow or overflow value.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_INC  = 3'b010,
        OP_PASS = 3'b011,
        OP_AND  = 3'b100,
        OP_OR   = 3'b101,
        OP_XOR  = 3'b110,
        OP_NOTA = 3'b111
    } alu8_op_t;

    // Selector codes on {Y,Z} for the logic path when X is set
    typedef enum logic [1:0] {
        LG_AND  = 2'b00,
        LG_OR   = 2'b01,
        LG_XOR  = 2'b10,
        LG_NOTA = 2'b11
    } alu8_logic_t;

endpackage

// File: rtl/alu8_ext_cell.sv
module alu8_ext_cell
    import alu8_pkg::*;
(
    input  logic     a_bit,
    input  logic     b_bit,
    input  alu8_op_t op,
    output logic     ia_bit,
    output logic     ib_bit
);

    logic        b_sel;
    logic        logic_bit;
    alu8_logic_t lsel;

    always_comb begin
        lsel = alu8_logic_t'(op[1:0]);
        // first selector: true or inverted B, chosen by Z
        b_sel = op[0] ? ~b_bit : b_bit;

        unique case (lsel)
            LG_AND:  logic_bit = a_bit & b_bit;
            LG_OR:   logic_bit = a_bit | b_bit;
            LG_XOR:  logic_bit = a_bit ^ b_bit;
            LG_NOTA: logic_bit = ~a_bit;
        endcase

        // X clear: A goes straight through; X set: logic result
        ia_bit = op[2] ? logic_bit : a_bit;
        // B reaches the adder only when both X and Y are clear
        ib_bit = (!op[2] && !op[1]) ? b_sel : 1'b0;
    end

endmodule

// File: rtl/alu8_cin_gen.sv
module alu8_cin_gen
    import alu8_pkg::*;
(
    input  alu8_op_t op,
    output logic     cin
);

    always_comb begin
        unique case (op)
            OP_SUB, OP_INC: cin = 1'b1;
            OP_ADD, OP_PASS, OP_AND, OP_OR, OP_XOR, OP_NOTA: cin = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu8_full_add.sv
module alu8_full_add (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);

    logic p;

    always_comb begin
        p  = x ^ y;
        s  = p ^ ci;
        co = (x & y) | (p & ci);
    end

endmodule

// File: rtl/alu8_ripple_adder.sv
module alu8_ripple_adder #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_vec,
    input  logic [WIDTH-1:0] y_vec,
    input  logic             ci,
    output logic [WIDTH-1:0] sum,
    output logic             co
);

    logic [WIDTH:0] chain;

    assign chain[0] = ci;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        alu8_full_add u_fa (
            .x  (x_vec[i]),
            .y  (y_vec[i]),
            .ci (chain[i]),
            .s  (sum[i]),
            .co (chain[i+1])
        );
    end

    assign co = chain[WIDTH];

endmodule

// File: rtl/alu8_top.sv
module alu8_top
    import alu8_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [2:0]       op_sel,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);

    alu8_op_t         op;
    logic [WIDTH-1:0] ia_vec;
    logic [WIDTH-1:0] ib_vec;
    logic             adder_cin;

    assign op = alu8_op_t'(op_sel);

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        alu8_ext_cell u_cell (
            .a_bit  (a_in[i]),
            .b_bit  (b_in[i]),
            .op     (op),
            .ia_bit (ia_vec[i]),
            .ib_bit (ib_vec[i])
        );
    end

    alu8_cin_gen u_cin (
        .op  (op),
        .cin (adder_cin)
    );

    alu8_ripple_adder #(.WIDTH(WIDTH)) u_add (
        .x_vec (ia_vec),
        .y_vec (ib_vec),
        .ci    (adder_cin),
        .sum   (result_o),
        .co    (carry_o)
    );

endmodule

// File: rtl/alu8_checker.sv
module alu8_checker #(
    parameter int WIDTH = 4
) (
    input logic [2:0]       op_sel,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] ia_vec,
    input logic [WIDTH-1:0] ib_vec,
    input logic             cin,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o
);

    logic [WIDTH:0] wide_a;
    logic [WIDTH:0] wide_b;
    logic [WIDTH:0] got;

    always_comb begin
        wide_a = {1'b0, a_in};
        wide_b = {1'b0, b_in};
        got    = {carry_o, result_o};

        if (op_sel == 3'b000)
            p_add_r1: assert (got == wide_a + wide_b)
                else $error("R1 add mismatch");
        if (op_sel == 3'b001)
            p_sub_r2: assert ((result_o == a_in - b_in) && (carry_o == (a_in >= b_in)))
                else $error("R2 subtract mismatch");
        if (op_sel == 3'b010)
            p_inc_r3: assert (got == wide_a + 1'b1)
                else $error("R3 increment mismatch");
        if (op_sel == 3'b011)
            p_pass_r4: assert (got == wide_a)
                else $error("R4 pass mismatch");
        if (op_sel == 3'b111)
            p_nota_r8: assert ((result_o == ~a_in) && !carry_o)
                else $error("R8 complement mismatch");
        if (op_sel[2])
            p_logic_no_carry_r7: assert (!carry_o && (result_o == ia_vec))
                else $error("R5-R8 logic path not passed through");
        if (op_sel[2] || op_sel[1])
            p_ib_zero_r10: assert (ib_vec == '0)
                else $error("R10 second adder input not zero");
        p_cin_r10: assert (cin == ((op_sel == 3'b001) || (op_sel == 3'b010)))
            else $error("R10 carry-in wrong");
    end

endmodule

bind alu8_top alu8_checker #(.WIDTH(WIDTH)) u_chk (
    .op_sel   (op_sel),
    .a_in     (a_in),
    .b_in     (b_in),
    .ia_vec   (ia_vec),
    .ib_vec   (ib_vec),
    .cin      (adder_cin),
    .result_o (result_o),
    .carry_o  (carry_o)
);

// File: tb/tb_alu8_top.sv
module tb_alu8_top;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_sel;
    logic [W-1:0] a_in;
    logic [W-1:0] b_in;
    logic [W-1:0] result_o;
    logic         carry_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    alu8_top #(.WIDTH(W)) dut (
        .op_sel   (op_sel),
        .a_in     (a_in),
        .b_in     (b_in),
        .result_o (result_o),
        .carry_o  (carry_o)
    );

    // {op, a, b, carry, result}
    localparam int NVEC = 14;
    localparam logic [15:0] VEC [NVEC] = '{
        {3'b000, 4'h7, 4'h1, 1'b0, 4'h8},  // R1
        {3'b000, 4'hF, 4'h1, 1'b1, 4'h0},  // R1 wrap
        {3'b000, 4'h8, 4'h8, 1'b1, 4'h0},  // R1
        {3'b001, 4'h5, 4'h3, 1'b1, 4'h2},  // R2
        {3'b001, 4'h3, 4'h5, 1'b0, 4'hE},  // R2 borrow
        {3'b001, 4'h0, 4'h0, 1'b1, 4'h0},  // R2 full ripple
        {3'b010, 4'hF, 4'h3, 1'b1, 4'h0},  // R3 full ripple
        {3'b010, 4'h6, 4'h0, 1'b0, 4'h7},  // R3
        {3'b011, 4'h9, 4'hF, 1'b0, 4'h9},  // R4
        {3'b100, 4'hC, 4'hA, 1'b0, 4'h8},  // R5
        {3'b101, 4'hC, 4'hA, 1'b0, 4'hE},  // R6
        {3'b110, 4'hC, 4'hA, 1'b0, 4'h6},  // R7
        {3'b111, 4'h5, 4'h0, 1'b0, 4'hA},  // R8
        {3'b111, 4'h0, 4'hF, 1'b0, 4'hF}   // R8
    };

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b011:  return "R4";
            3'b100:  return "R5";
            3'b101:  return "R6";
            3'b110:  return "R7";
            default: return "R8";
        endcase
    endfunction

    // reference model written from the requirements
    function automatic logic [W:0] model(input logic [2:0] op,
                                         input logic [W-1:0] a,
                                         input logic [W-1:0] b);
        logic [W:0] r;
        case (op)
            3'b000:  r = {1'b0, a} + {1'b0, b};
            3'b001:  r = {(a >= b), a - b};
            3'b010:  r = {1'b0, a} + 1;
            3'b011:  r = {1'b0, a};
            3'b100:  r = {1'b0, a & b};
            3'b101:  r = {1'b0, a | b};
            3'b110:  r = {1'b0, a ^ b};
            default: r = {1'b0, ~a};
        endcase
        return r;
    endfunction

    task automatic apply(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        op_sel = op;
        a_in   = a;
        b_in   = b;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [W:0] exp);
        checks++;
        if ({carry_o, result_o} !== exp) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h got c=%b r=%h expected c=%b r=%h",
                     tag, op_sel, a_in, b_in, carry_o, result_o, exp[W], exp[W-1:0]);
        end
    endtask

    initial begin : watchdog
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [W:0] ref0;
        op_sel = 3'b000;
        a_in   = '0;
        b_in   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset state", '0);
        rst_n = 1'b1;

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][15:13], VEC[i][12:9], VEC[i][8:5]);
            check(tag_of(VEC[i][15:13]), VEC[i][4:0]);
        end

        // exhaustive sweep of every opcode and operand pair
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    apply(3'(op), 4'(a), 4'(b));
                    check(tag_of(3'(op)), model(3'(op), 4'(a), 4'(b)));
                end

        // R9: B ignored for increment, pass and complement
        for (int k = 0; k < 3; k++) begin
            logic [2:0] op9;
            op9 = (k == 0) ? 3'b010 : (k == 1) ? 3'b011 : 3'b111;
            for (int a = 0; a < 16; a += 5) begin
                apply(op9, 4'(a), 4'h0);
                ref0 = {carry_o, result_o};
                for (int b = 1; b < 16; b++) begin
                    apply(op9, 4'(a), 4'(b));
                    check("R9", ref0);
                end
            end
        end

        // R10 visible at ports: subtract zero and increment all ones both ripple the whole chain
        apply(3'b001, 4'hA, 4'h0);
        check("R10", {1'b1, 4'hA});
        apply(3'b010, 4'hF, 4'hF);
        check("R10", {1'b1, 4'h0});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule